// File: doc/BRIEF.md
# Buffered Timer Compare Channel

This block is a single compare channel that sits beside a 16-bit timer counter. Software loads a 16-bit compare value over a byte-wide bus. The high byte is written first into a shared holding latch. Writing the low byte then commits all 16 bits at once. Reading the low byte also captures the matching high byte into the same latch, so a following high-byte read returns a coherent pair.

The block compares the running counter with the active compare value. On a timer tick where the two are equal, it emits a one-cycle match pulse for the waveform logic and sets a sticky flag. The flag, gated by an enable, requests an interrupt. The active value is also exported so that the counter can use it as its TOP.

The mode field selects how writes are applied. In direct modes, a committed write takes effect on the active value at once. In PWM modes, a committed write lands in a buffer. The buffer is copied to the active value only on the period strobe chosen by the mode, so the active value never changes in the middle of a period.

Top module: `ocmp_unit`

## Requirements
- R1: After reset, match_pulse, flag, irq, rd_data and top_value are all zero.
- R2: In direct modes (mode 0, 4 or 12), a write with wr_addr=1 only loads the holding latch and leaves top_value unchanged. A write with wr_addr=0 sets top_value to {latch, wr_data} from the next cycle.
- R3: In PWM modes (every mode except 0, 4 and 12), a write with wr_addr=0 commits {latch, wr_data} to the buffer only, and top_value is unchanged. On the selected update strobe, the buffer is copied into top_value.
- R4: Modes 8 and 9 take the buffer on bot_stb, and all other PWM modes take it on top_stb. The strobe that is not selected has no effect on top_value.
- R5: In a cycle where tick=1 and cnt equals top_value, match_pulse is high during the next cycle. match_pulse is low after every other cycle, including equal cycles with tick=0.
- R6: Such a match sets flag at the same edge that raises match_pulse, and flag then stays set until it is cleared.
- R7: irq is high exactly while flag=1 and irq_en=1.
- R8: flag clears at the next edge when irq_ack=1, or when flag_wr=1 with flag_wdata=1. flag_wr with flag_wdata=0 leaves flag unchanged.
- R9: When a match and a clear happen in the same cycle, the match wins and flag stays 1.
- R10: A read with rd_addr=0 puts the low byte of the visible value on rd_data from the next cycle. The visible value is the buffer in PWM modes and top_value in direct modes. The same read copies the visible value's high byte into the latch. A read with rd_addr=1 returns the latch. rd_data holds its value between reads.
- R11: The latch is shared between reads and writes. A low-byte read that falls between a high-byte write and a low-byte write replaces the high byte that the low-byte write commits. When a high-byte write and a low-byte read occur in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable |
| cnt | input | 16 | Running counter value |
| top_stb | input | 1 | Counter reached TOP |
| bot_stb | input | 1 | Counter reached BOTTOM |
| mode | input | 4 | Waveform mode field |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 1 | 0 = low byte, 1 = high byte |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 1 | 0 = low byte, 1 = high byte |
| rd_data | output | 8 | Registered read data |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt taken, clears flag |
| flag_wr | input | 1 | Software write to the flag bit |
| flag_wdata | input | 1 | Value written to the flag bit (1 clears) |
| match_pulse | output | 1 | One-cycle match to the waveform logic |
| flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |
| top_value | output | 16 | Active compare value, usable as counter TOP |

## Verification
The following results appear one edge after the cycle that caused them: match_pulse, flag, rd_data, top_value, the latch and the buffer. irq follows flag and irq_en with no extra delay. The bench drives every input on the falling edge. It advances a reference model at the rising edge using the inputs of the cycle just ending. It compares the outputs one time unit after that edge, so each result is checked in the first cycle in which it becomes due. Directed cases test the priority of a match over a clear, the strobe that is not selected, and a read that overwrites the latch, each against fixed expected constants.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int MODE_W = 4;

  function automatic logic mode_is_pwm(input logic [MODE_W-1:0] m);
    return !(m == 4'd0 || m == 4'd4 || m == 4'd12);
  endfunction

  function automatic logic mode_upd_bottom(input logic [MODE_W-1:0] m);
    return (m == 4'd8 || m == 4'd9);
  endfunction
endpackage

// File: rtl/ocmp_regif.sv
module ocmp_regif #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_addr,
  input  logic [CW-1:0] visible,
  output logic          commit,
  output logic [CW-1:0] commit_val,
  output logic [BW-1:0] rd_data
);
  logic [BW-1:0] hold_q;

  assign commit     = wr_en && !wr_addr;
  assign commit_val = {hold_q, wr_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && wr_addr)
        hold_q <= wr_data;
      else if (rd_en && !rd_addr)
        hold_q <= visible[CW-1:BW];
      if (rd_en)
        rd_data <= rd_addr ? hold_q : visible[BW-1:0];
    end
  end
endmodule

// File: rtl/ocmp_store.sv
module ocmp_store #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwm,
  input  logic          upd_bottom,
  input  logic          top_stb,
  input  logic          bot_stb,
  input  logic          commit,
  input  logic [CW-1:0] commit_val,
  output logic [CW-1:0] buf_q,
  output logic [CW-1:0] act_q
);
  logic upd;

  assign upd = pwm && (upd_bottom ? bot_stb : top_stb);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (commit)
        buf_q <= commit_val;
      if (!pwm && commit)
        act_q <= commit_val;
      else if (upd)
        act_q <= buf_q;
    end
  end
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic          irq_en,
  input  logic          irq_ack,
  input  logic          flag_wr,
  input  logic          flag_wdata,
  output logic          match_pulse,
  output logic          flag,
  output logic          irq
);
  logic hit, clr;

  assign hit = tick && (cnt == cmp);
  assign clr = irq_ack || (flag_wr && flag_wdata);
  assign irq = flag && irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_pulse <= 1'b0;
      flag        <= 1'b0;
    end else begin
      match_pulse <= hit;
      if (hit)
        flag <= 1'b1;
      else if (clr)
        flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick,
  input  logic [CW-1:0]               cnt,
  input  logic                        top_stb,
  input  logic                        bot_stb,
  input  logic [ocmp_pkg::MODE_W-1:0] mode,
  input  logic                        wr_en,
  input  logic                        wr_addr,
  input  logic [BW-1:0]               wr_data,
  input  logic                        rd_en,
  input  logic                        rd_addr,
  output logic [BW-1:0]               rd_data,
  input  logic                        irq_en,
  input  logic                        irq_ack,
  input  logic                        flag_wr,
  input  logic                        flag_wdata,
  output logic                        match_pulse,
  output logic                        flag,
  output logic                        irq,
  output logic [CW-1:0]               top_value
);
  import ocmp_pkg::*;

  logic          pwm, upd_bottom, commit;
  logic [CW-1:0] commit_val, buf_q, act_q, visible;

  assign pwm        = mode_is_pwm(mode);
  assign upd_bottom = mode_upd_bottom(mode);
  assign visible    = pwm ? buf_q : act_q;
  assign top_value  = act_q;

  ocmp_regif #(.BW(BW)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .visible(visible),
    .commit(commit), .commit_val(commit_val), .rd_data(rd_data)
  );

  ocmp_store #(.CW(CW)) u_store (
    .clk(clk), .rst(rst), .pwm(pwm), .upd_bottom(upd_bottom),
    .top_stb(top_stb), .bot_stb(bot_stb), .commit(commit),
    .commit_val(commit_val), .buf_q(buf_q), .act_q(act_q)
  );

  ocmp_match #(.CW(CW)) u_match (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cmp(act_q),
    .irq_en(irq_en), .irq_ack(irq_ack), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .match_pulse(match_pulse), .flag(flag), .irq(irq)
  );
endmodule

// File: rtl/ocmp_unit_chk.sv
module ocmp_unit_chk #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        tick,
  input logic [CW-1:0]               cnt,
  input logic                        top_stb,
  input logic                        bot_stb,
  input logic [ocmp_pkg::MODE_W-1:0] mode,
  input logic                        wr_en,
  input logic                        wr_addr,
  input logic                        irq_ack,
  input logic                        flag,
  input logic                        match_pulse,
  input logic [CW-1:0]               top_value
);
  import ocmp_pkg::*;

  logic pwm, sel_stb, hit;
  assign pwm     = mode_is_pwm(mode);
  assign sel_stb = mode_upd_bottom(mode) ? bot_stb : top_stb;
  assign hit     = tick && (cnt == top_value);

  // R5
  match_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> $past(tick));

  // R6
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> flag);

  // R9
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !hit) |=> !flag);

  // R2
  direct_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pwm && !(wr_en && !wr_addr)) |=> $stable(top_value));

  // R3
  pwm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm && !sel_stb) |=> $stable(top_value));
endmodule

bind ocmp_unit ocmp_unit_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .top_stb(top_stb), .bot_stb(bot_stb),
  .mode(mode), .wr_en(wr_en), .wr_addr(wr_addr), .irq_ack(irq_ack), .flag(flag),
  .match_pulse(match_pulse), .top_value(top_value)
);

// File: tb/ocmp_unit_tb.sv
module ocmp_unit_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic tick = 0, top_stb = 0, bot_stb = 0, wr_en = 0, wr_addr = 0, rd_en = 0, rd_addr = 0;
  logic irq_en = 0, irq_ack = 0, flag_wr = 0, flag_wdata = 0;
  logic [15:0] cnt = '0;
  logic [3:0]  mode = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        match_pulse, flag, irq;
  logic [15:0] top_value;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_act = 0, m_buf = 0;
  logic [7:0]  m_tmp = 0, m_rd = 0;
  logic        m_flag = 0, m_match = 0;

  always #2 clk = ~clk;

  ocmp_unit u_dut (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .top_stb(top_stb), .bot_stb(bot_stb),
    .mode(mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_en(irq_en), .irq_ack(irq_ack),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .match_pulse(match_pulse), .flag(flag),
    .irq(irq), .top_value(top_value)
  );

  function automatic bit b_pwm(input logic [3:0] m);
    return !(m == 0 || m == 4 || m == 12);
  endfunction
  function automatic bit b_bot(input logic [3:0] m);
    return (m == 8 || m == 9);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    tick = 0; top_stb = 0; bot_stb = 0; wr_en = 0; rd_en = 0;
    irq_ack = 0; flag_wr = 0; flag_wdata = 0;
  endtask

  // Advance model with this cycle's inputs, then compare after the edge.
  task automatic cycle();
    logic [15:0] vis, cv;
    logic pwm, hit, upd;
    @(posedge clk);
    pwm = b_pwm(mode);
    vis = pwm ? m_buf : m_act;
    hit = tick && (cnt == m_act);
    upd = pwm && (b_bot(mode) ? bot_stb : top_stb);
    cv  = {m_tmp, wr_data};
    if (rd_en) m_rd = rd_addr ? m_tmp : vis[7:0];
    if (wr_en && wr_addr) m_tmp = wr_data;
    else if (rd_en && !rd_addr) m_tmp = vis[15:8];
    if (!pwm && wr_en && !wr_addr) m_act = cv;
    else if (upd) m_act = m_buf;
    if (wr_en && !wr_addr) m_buf = cv;
    if (hit) m_flag = 1;
    else if (irq_ack || (flag_wr && flag_wdata)) m_flag = 0;
    m_match = hit;
    #1;
    chk("R2/R3 top_value", top_value, m_act);
    chk("R5 match_pulse", {15'd0, match_pulse}, {15'd0, m_match});
    chk("R6 flag", {15'd0, flag}, {15'd0, m_flag});
    chk("R7 irq", {15'd0, irq}, {15'd0, m_flag && irq_en});
    chk("R10 rd_data", {8'd0, rd_data}, {8'd0, m_rd});
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    idle(); wr_en = 1; wr_addr = a; wr_data = d; cycle(); idle();
  endtask
  task automatic rd(input logic a);
    idle(); rd_en = 1; rd_addr = a; cycle(); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    chk("R1 flag", {15'd0, flag}, 16'd0);
    chk("R1 match", {15'd0, match_pulse}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 top_value", top_value, 16'd0);
    chk("R1 rd_data", {8'd0, rd_data}, 16'd0);
    @(negedge clk);

    // R2 direct mode
    mode = 0;
    wr(1, 8'h12); chk("R2 high write only latches", top_value, 16'h0000);
    wr(0, 8'h34); chk("R2 low write commits", top_value, 16'h1234);

    // R5/R6/R7 match
    irq_en = 0; cnt = 16'h1234; tick = 1; cycle(); idle();
    chk("R5 pulse", {15'd0, match_pulse}, 16'd1);
    chk("R6 flag set", {15'd0, flag}, 16'd1);
    chk("R7 irq gated", {15'd0, irq}, 16'd0);
    irq_en = 1; #0; cycle();
    chk("R5 no tick no pulse", {15'd0, match_pulse}, 16'd0);
    chk("R7 irq on", {15'd0, irq}, 16'd1);

    // R8 clears
    flag_wr = 1; flag_wdata = 0; cycle(); idle();
    chk("R8 write zero ignored", {15'd0, flag}, 16'd1);
    flag_wr = 1; flag_wdata = 1; cycle(); idle();
    chk("R8 write one clears", {15'd0, flag}, 16'd0);
    tick = 1; cycle(); idle();
    irq_ack = 1; cycle(); idle();
    chk("R8 ack clears", {15'd0, flag}, 16'd0);

    // R9 match beats clear
    tick = 1; irq_ack = 1; flag_wr = 1; flag_wdata = 1; cycle(); idle();
    chk("R9 set wins", {15'd0, flag}, 16'd1);
    irq_ack = 1; cycle(); idle();
    cnt = 16'h0;

    // R3/R4 PWM with TOP update
    mode = 14;
    wr(1, 8'hAB); wr(0, 8'hCD);
    chk("R3 buffered", top_value, 16'h1234);
    bot_stb = 1; cycle(); idle();
    chk("R4 unselected strobe ignored", top_value, 16'h1234);
    top_stb = 1; cycle(); idle();
    chk("R4 top strobe updates", top_value, 16'hABCD);

    // R4 BOTTOM-update mode
    mode = 8;
    wr(1, 8'h00); wr(0, 8'h10);
    top_stb = 1; cycle(); idle();
    chk("R4 top ignored in mode 8", top_value, 16'hABCD);
    bot_stb = 1; cycle(); idle();
    chk("R4 bottom updates", top_value, 16'h0010);

    // R10 reads
    wr(1, 8'h55); wr(0, 8'h66);
    rd(0); chk("R10 low reads buffer", {8'd0, rd_data}, 16'h0066);
    rd(1); chk("R10 high via latch", {8'd0, rd_data}, 16'h0055);
    mode = 0;
    rd(0); chk("R10 low reads active", {8'd0, rd_data}, 16'h0010);
    cycle(); chk("R10 rd_data holds", {8'd0, rd_data}, 16'h0010);

    // R11 shared latch
    wr(1, 8'h77); rd(0); wr(0, 8'h01);
    chk("R11 read overwrote latch", top_value, 16'h0001);
    idle(); wr_en = 1; wr_addr = 1; wr_data = 8'h3C; rd_en = 1; rd_addr = 0; cycle(); idle();
    wr(0, 8'h02);
    chk("R11 write wins over read", top_value, 16'h3C02);

    // Random phase
    begin
      logic [3:0] modes [8] = '{4'd0, 4'd4, 4'd12, 4'd1, 4'd8, 4'd9, 4'd14, 4'd15};
      void'($urandom(32'h5EED1));
      for (int s = 0; s < 8; s++) begin
        mode = modes[s];
        for (int i = 0; i < 1500; i++) begin
          tick = ($urandom % 3) != 0;
          cnt = (($urandom % 3) == 0) ? m_act : 16'($urandom);
          top_stb = ($urandom % 8) == 0;
          bot_stb = ($urandom % 8) == 0;
          wr_en = ($urandom % 6) == 0; wr_addr = 1'($urandom); wr_data = 8'($urandom);
          rd_en = ($urandom % 5) == 0; rd_addr = 1'($urandom);
          irq_en = 1'($urandom);
          irq_ack = ($urandom % 7) == 0;
          flag_wr = ($urandom % 7) == 0; flag_wdata = 1'($urandom);
          cycle();
        end
      end
      idle();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule